// File: doc/BRIEF.md
# LIN UART Transmit/Receive Status Unit

This block holds the status byte of a UART that runs in LIN mode. Eight single-bit flags report on the receive and transmit paths: a byte waiting in the receive holding register, a lost byte, a bad stop bit, a detected break, a free transmit holding register, an idle transmitter and a fault seen on the physical bus. A spare bit reads as zero. The flags are set by one-cycle event strobes from the shift registers, the break detector and the bit timer. They are cleared by CPU bus strobes: a write to the transmit holding register, a read of the receive holding register, or a read of the status byte itself.

While the node is driving the bus, the block compares each transmitted bit with the level sampled back from the receive line at that bit's mid-point. A difference in a start, data or stop bit means either a fault in the physical layer or another node driving the bus at the same time. Either case raises the physical-fault flag, and a read of the status byte or of the receive holding register clears it. If a set event and a clearing access fall in the same cycle, the set takes effect, so no event is lost. The block also chooses the flow-control level that gates the transmitter. Normally this is the external clear-to-send input. In loopback mode it is the internal receive-ready flag.

Top module: `lin_stat_unit`

## Requirements
- R1: After reset the status byte reads 0x06. The bit layout, MSB first, is: 7 rx_ready, 6 phy_fault, 5 rx_overrun, 4 frame_bad, 3 brk_seen, 2 txbuf_empty, 1 tx_idle, 0 spare. The spare bit always reads 0.
- R2: txbuf_empty becomes 1 at the clock edge after a txbuf_free strobe and 0 at the clock edge after a txd_wr strobe. When both strobes occur in the same cycle, it becomes 1.
- R3: tx_idle is registered. After each edge it equals 1 only if tx_shift_busy was 0 in the preceding cycle and txbuf_empty is 1 after that edge. It is therefore 0 while a character is being shifted out.
- R4: rx_ready becomes 1 after an rx_load strobe and 0 after an rxd_rd strobe. If the two strobes coincide, it stays 1.
- R5: rx_overrun becomes 1 when rx_load occurs while rx_ready is already 1. An rxd_rd strobe clears it.
- R6: frame_bad becomes 1 when rx_load occurs with rx_stop_bad high. An rxd_rd strobe clears it.
- R7: phy_fault becomes 1 at the edge after a cycle in which tx_active and mid_tick are both high and tx_bit differs from rx_line. A match, a cycle with mid_tick low, or a cycle with tx_active low leaves it unchanged.
- R8: phy_fault is cleared by a stat_rd strobe or by an rxd_rd strobe. A mismatch in the same cycle as either strobe leaves it at 1.
- R9: brk_seen becomes 1 after a brk_det strobe. Only stat_rd clears it; rxd_rd has no effect on it.
- R10: flow_ok equals cts_in when loopback is 0 and equals rx_ready when loopback is 1, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_rd | input | 1 | CPU read of the status byte (strobe) |
| rxd_rd | input | 1 | CPU read of the receive holding register (strobe) |
| txd_wr | input | 1 | CPU write of the transmit holding register (strobe) |
| txbuf_free | input | 1 | Transmit holding register has moved its byte to the shifter (strobe) |
| tx_shift_busy | input | 1 | Transmit shifter is sending a character (level) |
| rx_load | input | 1 | Received byte placed in the receive holding register (strobe) |
| rx_stop_bad | input | 1 | Stop bit of the byte given with rx_load was invalid |
| brk_det | input | 1 | Break detected on the receive line (strobe) |
| tx_active | input | 1 | Node is currently driving a bit onto the bus |
| tx_bit | input | 1 | Level being driven |
| rx_line | input | 1 | Level sampled from the bus |
| mid_tick | input | 1 | Mid-bit sampling strobe |
| loopback | input | 1 | Loopback mode select |
| cts_in | input | 1 | External clear-to-send level |
| status | output | 8 | Status byte |
| flow_ok | output | 1 | Flow-control level for the transmitter |

## Verification
The bit-echo comparison is exercised with four patterns: matching levels, a mismatch with mid_tick low, a mismatch with tx_active low, and a genuine mismatch. Only the last pattern may raise phy_fault, which shows that both qualifiers take part in the comparison. Each flag is driven through its set strobe, its own clearing access, and an unrelated clearing access. This reveals any cross-wired clear, such as a receive read that wipes the break flag. Set and clear strobes are also applied in the same cycle to confirm that the set takes effect, and a second byte is loaded into an occupied receive register to separate the overrun path from the plain load.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;

    localparam int FLAG_N = 6;

    localparam int F_RXRDY = 0;
    localparam int F_PHY   = 1;
    localparam int F_OVR   = 2;
    localparam int F_FRM   = 3;
    localparam int F_BRK   = 4;
    localparam int F_TXE   = 5;

    localparam logic [FLAG_N-1:0] FLAG_RST = 6'b10_0000;

    typedef struct packed {
        logic rx_ready;
        logic phy_fault;
        logic rx_overrun;
        logic frame_bad;
        logic brk_seen;
        logic txbuf_empty;
        logic tx_idle;
        logic spare;
    } lin_status_t;

    function automatic lin_status_t pack_status(input logic [FLAG_N-1:0] f,
                                                input logic idle);
        lin_status_t s;
        s.rx_ready    = f[F_RXRDY];
        s.phy_fault   = f[F_PHY];
        s.rx_overrun  = f[F_OVR];
        s.frame_bad   = f[F_FRM];
        s.brk_seen    = f[F_BRK];
        s.txbuf_empty = f[F_TXE];
        s.tx_idle     = idle;
        s.spare       = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/lin_stat_flag.sv
module lin_stat_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q,
    output logic nxt
);
    assign nxt = set | (q & ~clr);

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= nxt;
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst) set |=> q);
    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst) (clr && !set) |=> !q);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst) (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/lin_stat_echo.sv
module lin_stat_echo (
    input  logic tx_active,
    input  logic mid_tick,
    input  logic tx_bit,
    input  logic rx_line,
    output logic mismatch
);
    logic sample_now;
    assign sample_now = tx_active & mid_tick;
    assign mismatch   = sample_now & (tx_bit ^ rx_line);

    // R7
    always_comb begin
        if (!tx_active || !mid_tick)
            echo_qual_chk: assert (!mismatch);
    end
endmodule

// File: rtl/lin_stat_txidle.sv
module lin_stat_txidle (
    input  logic clk,
    input  logic rst,
    input  logic shift_busy,
    input  logic buf_empty_nxt,
    output logic idle
);
    always_ff @(posedge clk) begin
        if (rst) idle <= 1'b1;
        else     idle <= ~shift_busy & buf_empty_nxt;
    end

    // R3
    busy_not_idle_chk: assert property (@(posedge clk) disable iff (rst) shift_busy |=> !idle);
endmodule

// File: rtl/lin_stat_unit.sv
module lin_stat_unit
    import lin_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stat_rd,
    input  logic       rxd_rd,
    input  logic       txd_wr,
    input  logic       txbuf_free,
    input  logic       tx_shift_busy,
    input  logic       rx_load,
    input  logic       rx_stop_bad,
    input  logic       brk_det,
    input  logic       tx_active,
    input  logic       tx_bit,
    input  logic       rx_line,
    input  logic       mid_tick,
    input  logic       loopback,
    input  logic       cts_in,
    output logic [7:0] status,
    output logic       flow_ok
);
    logic [FLAG_N-1:0] set_v, clr_v, q_v, nxt_v;
    logic              echo_bad;
    logic              idle_q;
    lin_status_t       st;

    lin_stat_echo u_echo (
        .tx_active (tx_active),
        .mid_tick  (mid_tick),
        .tx_bit    (tx_bit),
        .rx_line   (rx_line),
        .mismatch  (echo_bad)
    );

    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[F_RXRDY] = rx_load;
        clr_v[F_RXRDY] = rxd_rd;
        set_v[F_PHY]   = echo_bad;
        clr_v[F_PHY]   = stat_rd | rxd_rd;
        set_v[F_OVR]   = rx_load & q_v[F_RXRDY];
        clr_v[F_OVR]   = rxd_rd;
        set_v[F_FRM]   = rx_load & rx_stop_bad;
        clr_v[F_FRM]   = rxd_rd;
        set_v[F_BRK]   = brk_det;
        clr_v[F_BRK]   = stat_rd;
        set_v[F_TXE]   = txbuf_free;
        clr_v[F_TXE]   = txd_wr;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        lin_stat_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
            .clk (clk),
            .rst (rst),
            .set (set_v[i]),
            .clr (clr_v[i]),
            .q   (q_v[i]),
            .nxt (nxt_v[i])
        );
    end

    lin_stat_txidle u_idle (
        .clk           (clk),
        .rst           (rst),
        .shift_busy    (tx_shift_busy),
        .buf_empty_nxt (nxt_v[F_TXE]),
        .idle          (idle_q)
    );

    assign st      = pack_status(q_v, idle_q);
    assign status  = st;
    assign flow_ok = loopback ? st.rx_ready : cts_in;

    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_load && status[7]) |=> status[5]);
    // R7
    echo_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_active && mid_tick && (tx_bit != rx_line)) |=> status[6]);
    // R2
    txbuf_write_chk: assert property (@(posedge clk) disable iff (rst)
        (txd_wr && !txbuf_free) |=> (!status[2] && !status[1]));
endmodule

// File: tb/lin_stat_unit_test.sv
`timescale 1ns/1ps
module lin_stat_unit_test;
    logic clk = 1'b0;
    logic rst;
    logic stat_rd, rxd_rd, txd_wr, txbuf_free, tx_shift_busy;
    logic rx_load, rx_stop_bad, brk_det;
    logic tx_active, tx_bit, rx_line, mid_tick, loopback, cts_in;
    logic [7:0] status;
    logic flow_ok;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lin_stat_unit uut (
        .clk(clk), .rst(rst), .stat_rd(stat_rd), .rxd_rd(rxd_rd), .txd_wr(txd_wr),
        .txbuf_free(txbuf_free), .tx_shift_busy(tx_shift_busy), .rx_load(rx_load),
        .rx_stop_bad(rx_stop_bad), .brk_det(brk_det), .tx_active(tx_active),
        .tx_bit(tx_bit), .rx_line(rx_line), .mid_tick(mid_tick), .loopback(loopback),
        .cts_in(cts_in), .status(status), .flow_ok(flow_ok)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        stat_rd = 0; rxd_rd = 0; txd_wr = 0; txbuf_free = 0; tx_shift_busy = 0;
        rx_load = 0; rx_stop_bad = 0; brk_det = 0; tx_active = 0; tx_bit = 1;
        rx_line = 1; mid_tick = 0; loopback = 0; cts_in = 1;
    endtask

    task automatic t_reset();
        rst = 1; cyc(); cyc(); rst = 0; cyc();
        chk("R1 reset value", status, 8'h06);
        chk("R10 flow follows cts", {7'd0, flow_ok}, 8'h01);
    endtask

    task automatic t_tx();
        txd_wr = 1; cyc(); txd_wr = 0;
        chk("R2 write clears txbuf_empty, R3 idle low", status, 8'h00);
        tx_shift_busy = 1; txbuf_free = 1; cyc(); txbuf_free = 0;
        chk("R3 busy keeps tx_idle low, R2 free sets", status, 8'h04);
        cyc();
        chk("R3 still busy", status, 8'h04);
        tx_shift_busy = 0; cyc();
        chk("R3 idle after shift done", status, 8'h06);
        txd_wr = 1; txbuf_free = 1; cyc(); txd_wr = 0; txbuf_free = 0;
        chk("R2 free wins over write", status, 8'h06);
    endtask

    task automatic t_rx();
        rx_load = 1; cyc(); rx_load = 0;
        chk("R4 load sets rx_ready", status, 8'h86);
        rx_load = 1; cyc(); rx_load = 0;
        chk("R5 second load sets overrun", status, 8'hA6);
        rxd_rd = 1; cyc(); rxd_rd = 0;
        chk("R4 R5 read clears", status, 8'h06);
        rx_load = 1; rx_stop_bad = 1; cyc(); rx_load = 0; rx_stop_bad = 0;
        chk("R6 bad stop sets frame_bad", status, 8'h96);
        rx_load = 1; rxd_rd = 1; cyc(); rx_load = 0; rxd_rd = 0;
        chk("R4 load wins over read, R6 cleared", status, 8'hA6);
        rxd_rd = 1; cyc(); rxd_rd = 0;
        chk("R5 read clears overrun", status, 8'h06);
    endtask

    task automatic t_echo();
        tx_active = 1; mid_tick = 1; tx_bit = 1; rx_line = 1; cyc();
        chk("R7 match no fault", status, 8'h06);
        tx_bit = 0; mid_tick = 0; cyc();
        chk("R7 no mid_tick no fault", status, 8'h06);
        tx_active = 0; mid_tick = 1; cyc();
        chk("R7 not transmitting no fault", status, 8'h06);
        tx_active = 1; cyc(); tx_active = 0; mid_tick = 0;
        chk("R7 mismatch sets phy_fault", status, 8'h46);
        stat_rd = 1; cyc(); stat_rd = 0;
        chk("R8 status read clears", status, 8'h06);
        tx_active = 1; mid_tick = 1; cyc(); tx_active = 0; mid_tick = 0;
        rxd_rd = 1; cyc(); rxd_rd = 0;
        chk("R8 data read clears", status, 8'h06);
        tx_active = 1; mid_tick = 1; stat_rd = 1; cyc();
        tx_active = 0; mid_tick = 0; stat_rd = 0;
        chk("R8 mismatch wins over read", status, 8'h46);
        stat_rd = 1; cyc(); stat_rd = 0; tx_bit = 1;
        chk("R8 cleared again", status, 8'h06);
    endtask

    task automatic t_break();
        brk_det = 1; cyc(); brk_det = 0;
        chk("R9 break sets", status, 8'h0E);
        rxd_rd = 1; cyc(); rxd_rd = 0;
        chk("R9 data read ignored", status, 8'h0E);
        stat_rd = 1; cyc(); stat_rd = 0;
        chk("R9 status read clears", status, 8'h06);
    endtask

    task automatic t_flow();
        loopback = 1; cts_in = 1; #1;
        chk("R10 loopback uses rx_ready low", {7'd0, flow_ok}, 8'h00);
        rx_load = 1; cyc(); rx_load = 0;
        chk("R10 loopback uses rx_ready high", {7'd0, flow_ok}, 8'h01);
        loopback = 0; cts_in = 0; #1;
        chk("R10 external cts low", {7'd0, flow_ok}, 8'h00);
        rxd_rd = 1; cyc(); rxd_rd = 0;
        chk("R1 spare bit zero", {7'd0, status[0]}, 8'h00);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        t_reset();
        t_tx();
        t_rx();
        t_echo();
        t_break();
        t_flow();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule